// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator

This block watches the running minute, hour and day-of-week values of a real-time clock and raises an alarm when they equal a programmed alarm time. It keeps three alarm registers (minute, hour, day) on a byte-wide register bus, and it keeps the alarm flag and the alarm interrupt mask of the command register. The counting of time is done elsewhere. The counter supplies its BCD fields and a one-cycle pulse, `minute_tick`, in the clock cycle in which those fields first show a new minute.

Bit 7 of each alarm register is a "don't care" mask that takes the field out of the comparison. With the minute field masked, the alarm fires every minute while the hour and day agree. With only the day left compared, it fires every minute of that day. With all three fields masked, it fires on every minute rollover. The hour alarm uses the same encoding as the hours counter: bit 6 set selects 12-hour mode, and bit 5 is then the PM indicator (in 24-hour mode bit 5 is the twenties digit). Software reads the command register to collect and clear the flag. The interrupt request follows the flag unless the mask bit in the command register is set.

Top module: `tod_alarm`

## Requirements
- R1: After reset the three alarm registers read 0x00, the command register reads 0x04 (mask bit 2 set, flag bit 0 clear), and `irq` and `tod_flag` are low.
- R2: Writes to address 3 (minute alarm), 5 (hour alarm) and 7 (day alarm) store all eight bits, and reads of those addresses return them.
- R3: At address 0xB, bit 2 is the writable interrupt mask and bit 0 is the read-only alarm flag. Writing bit 0 has no effect, and the other bits read as zero.
- R4: With minute-alarm bit 7 clear, the minute field matches only when alarm bits 6:0 equal `cur_min` bits 6:0.
- R5: With hour-alarm bit 7 clear, the hour field matches only when alarm bits 6:0 equal `cur_hour` bits 6:0. This comparison includes the 12/24 bit 6 and the AM/PM bit 5, so the same digits in a different mode or half-day do not match.
- R6: With day-alarm bit 7 clear, the day field matches only when alarm bits 2:0 equal `cur_day` bits 2:0.
- R7: A field whose alarm bit 7 is set always matches. With all three masks set, every `minute_tick` sets the flag.
- R8: The flag sets only in a cycle with `minute_tick` high and all fields matching. Matching time values without a tick leave it clear.
- R9: Once set, the flag stays set until the command register is read. That read returns bit 0 = 1, and the flag is clear from the next cycle.
- R10: When a flag-setting tick and a command-register read fall in the same cycle, the read returns the old flag and the flag is set afterwards.
- R11: `irq` is high exactly while the flag is set and the mask bit is clear. Changing the mask changes `irq` without touching the flag.
- R12: Writes to any other address leave all readable state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; a read of 0xB clears the flag |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en`, zero otherwise |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, same encoding as the hour alarm |
| cur_day | input | 8 | Current day of week, 1 to 7 in bits 2:0 |
| minute_tick | input | 1 | One-cycle pulse when the time fields show a new minute |
| tod_flag | output | 1 | Alarm flag (command register bit 0) |
| irq | output | 1 | Alarm interrupt request |

## Verification
A stored alarm register that has been corrupted shows up at the ports in one of two ways. It reads back wrong on the next read of its address, or it sets the flag on the wrong tick or fails to set it, and either is visible the cycle after that tick. A stuck or wrongly cleared flag register shows up at once on `tod_flag` and `irq`, and in bit 0 of the next command read. A fault in the mask bit shows up in the same cycle as a disagreement between `irq` and `tod_flag`. The stimulus pairs each field's match with a near miss that differs in only that field, so a comparator looking at the wrong bits fails on the first tick.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
  localparam int unsigned ADDR_W   = 6;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned N_FIELDS = 3;

  localparam logic [ADDR_W-1:0] A_MIN  = 6'h03;
  localparam logic [ADDR_W-1:0] A_HOUR = 6'h05;
  localparam logic [ADDR_W-1:0] A_DAY  = 6'h07;
  localparam logic [ADDR_W-1:0] A_CMD  = 6'h0B;

  localparam int unsigned CMD_FLAG_BIT = 0;
  localparam int unsigned CMD_MASK_BIT = 2;

  typedef struct packed {
    logic       dc;
    logic [6:0] val;
  } alarm_reg_t;

  typedef enum logic [1:0] {
    F_MIN  = 2'd0,
    F_HOUR = 2'd1,
    F_DAY  = 2'd2
  } field_e;
endpackage

// File: rtl/ta_regs.sv
module ta_regs
  import tod_alarm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output alarm_reg_t    alm_min,
  output alarm_reg_t    alm_hour,
  output alarm_reg_t    alm_day,
  output logic          irq_mask
);
  alarm_reg_t min_q, hour_q, day_q;
  alarm_reg_t min_d, hour_d, day_d;
  logic       mask_q, mask_d;
  logic       we_min, we_hour, we_day, we_cmd;

  always_comb begin
    we_min  = wr_en && (addr == A_MIN[AW-1:0]);
    we_hour = wr_en && (addr == A_HOUR[AW-1:0]);
    we_day  = wr_en && (addr == A_DAY[AW-1:0]);
    we_cmd  = wr_en && (addr == A_CMD[AW-1:0]);
    min_d   = we_min  ? alarm_reg_t'(wdata) : min_q;
    hour_d  = we_hour ? alarm_reg_t'(wdata) : hour_q;
    day_d   = we_day  ? alarm_reg_t'(wdata) : day_q;
    mask_d  = we_cmd  ? wdata[CMD_MASK_BIT] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      min_q  <= '0;
      hour_q <= '0;
      day_q  <= '0;
      mask_q <= 1'b1;
    end else begin
      min_q  <= min_d;
      hour_q <= hour_d;
      day_q  <= day_d;
      mask_q <= mask_d;
    end
  end

  assign alm_min  = min_q;
  assign alm_hour = hour_q;
  assign alm_day  = day_q;
  assign irq_mask = mask_q;
endmodule

// File: rtl/ta_match.sv
module ta_match
  import tod_alarm_pkg::*;
(
  input  alarm_reg_t alm_min,
  input  alarm_reg_t alm_hour,
  input  alarm_reg_t alm_day,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_day,
  output logic       all_match
);
  alarm_reg_t alm   [N_FIELDS];
  logic [6:0] cur   [N_FIELDS];
  logic [6:0] sel   [N_FIELDS];
  logic [N_FIELDS-1:0] hit;

  always_comb begin
    alm[F_MIN]  = alm_min;
    alm[F_HOUR] = alm_hour;
    alm[F_DAY]  = alm_day;
    cur[F_MIN]  = cur_min[6:0];
    cur[F_HOUR] = cur_hour[6:0];
    cur[F_DAY]  = cur_day[6:0];
    sel[F_MIN]  = 7'h7F;
    sel[F_HOUR] = 7'h7F;
    sel[F_DAY]  = 7'h07;
  end

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    assign hit[g] = alm[g].dc || (((alm[g].val ^ cur[g]) & sel[g]) == 7'h00);
  end

  assign all_match = &hit;
endmodule

// File: rtl/ta_flag.sv
module ta_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match,
  input  logic clr,
  input  logic irq_mask,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d, set_en;

  always_comb begin
    set_en = tick && match;
    if (set_en)   flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = flag_q && !irq_mask;
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
  import tod_alarm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [7:0]    cur_min,
  input  logic [7:0]    cur_hour,
  input  logic [7:0]    cur_day,
  input  logic          minute_tick,
  output logic          tod_flag,
  output logic          irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  alarm_reg_t alm_min, alm_hour, alm_day;
  logic       tdm, all_match, cmd_rd;
  logic [7:0] cmd_val, rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ta_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day), .irq_mask(tdm)
  );

  ta_match u_match (
    .alm_min(alm_min), .alm_hour(alm_hour), .alm_day(alm_day),
    .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .all_match(all_match)
  );

  assign cmd_rd = rd_en && (addr == A_CMD[AW-1:0]);

  ta_flag u_flag (
    .clk(clk), .rst_n(rst_int_n), .tick(minute_tick), .match(all_match),
    .clr(cmd_rd), .irq_mask(tdm), .flag(tod_flag), .irq(irq)
  );

  always_comb begin
    cmd_val = '0;
    cmd_val[CMD_FLAG_BIT] = tod_flag;
    cmd_val[CMD_MASK_BIT] = tdm;
    if (addr == A_MIN[AW-1:0])       rd_mux = alm_min;
    else if (addr == A_HOUR[AW-1:0]) rd_mux = alm_hour;
    else if (addr == A_DAY[AW-1:0])  rd_mux = alm_day;
    else if (addr == A_CMD[AW-1:0])  rd_mux = cmd_val;
    else                             rd_mux = '0;
    rdata = rd_en ? rd_mux : 8'h00;
  end
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk
  import tod_alarm_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input logic          clk,
  input logic          rst_int_n,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [7:0]    rdata,
  input logic          minute_tick,
  input logic          all_match,
  input logic          tdm,
  input logic          tod_flag,
  input logic          irq
);
  logic cmd_rd;
  assign cmd_rd = rd_en && (addr == A_CMD[AW-1:0]);

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq |-> (tod_flag && !tdm));

  p_set_needs_tick_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(tod_flag) |-> $past(minute_tick && all_match));

  p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tod_flag && !cmd_rd) |=> tod_flag);

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cmd_rd && !minute_tick) |=> !tod_flag);

  p_tick_sets_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (minute_tick && all_match) |=> tod_flag);

  p_cmd_read_flag_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_rd |-> (rdata[CMD_FLAG_BIT] == tod_flag && rdata[CMD_MASK_BIT] == tdm));
endmodule

bind tod_alarm tod_alarm_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .minute_tick(minute_tick), .all_match(all_match), .tdm(tdm),
  .tod_flag(tod_flag), .irq(irq)
);

// File: tb/test_tod_alarm.sv
module test_tod_alarm;
  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  localparam int K_RD = 0;
  localparam int K_IRQ = 1;
  localparam int K_FLG = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, minute_tick = 1'b0, chk_go = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, cur_min = '0, cur_hour = '0, cur_day = '0;
  logic [7:0] rdata;
  logic       tod_flag, irq;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;
  item_t      sb[$];

  always #5 clk = ~clk;

  tod_alarm i_tod_alarm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_day(cur_day), .minute_tick(minute_tick), .tod_flag(tod_flag), .irq(irq)
  );

  always @(negedge clk) begin
    if (chk_go) begin
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb.pop_front();
        case (it.kind)
          K_RD:    got = rdata;
          K_IRQ:   got = {7'b0, irq};
          default: got = {7'b0, tod_flag};
        endcase
        n_chk++;
        if (got !== it.exp) begin
          n_err++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(posedge clk); #1 wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1 rd_en = 1'b1; addr = a; chk_go = 1'b1;
    sb.push_back('{K_RD, e, tag});
    @(posedge clk); #1 rd_en = 1'b0; chk_go = 1'b0;
  endtask

  task automatic outs(input logic f, input logic i, input string tag);
    @(posedge clk); #1 chk_go = 1'b1;
    sb.push_back('{K_FLG, {7'b0, f}, tag});
    sb.push_back('{K_IRQ, {7'b0, i}, tag});
    @(posedge clk); #1 chk_go = 1'b0;
  endtask

  task automatic tick(input logic [7:0] m, input logic [7:0] h, input logic [7:0] d);
    @(posedge clk); #1 cur_min = m; cur_hour = h; cur_day = d; minute_tick = 1'b1;
    @(posedge clk); #1 minute_tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    // R1 reset state
    rd(6'h03, 8'h00, "R1 min alarm"); rd(6'h05, 8'h00, "R1 hour alarm");
    rd(6'h07, 8'h00, "R1 day alarm"); rd(6'h0B, 8'h04, "R1 cmd");
    outs(1'b0, 1'b0, "R1 outputs");
    // R2 storage
    wr(6'h03, 8'h30); wr(6'h05, 8'h08); wr(6'h07, 8'h03);
    rd(6'h03, 8'h30, "R2 min"); rd(6'h05, 8'h08, "R2 hour"); rd(6'h07, 8'h03, "R2 day");
    wr(6'h03, 8'hD9); rd(6'h03, 8'hD9, "R2 all bits"); wr(6'h03, 8'h30);
    // R3 command layout
    wr(6'h0B, 8'hFF); rd(6'h0B, 8'h04, "R3 write ff");
    wr(6'h0B, 8'h00); rd(6'h0B, 8'h00, "R3 unmask");
    // R12 stray write
    wr(6'h04, 8'hAA); wr(6'h0C, 8'h55);
    rd(6'h03, 8'h30, "R12 min"); rd(6'h05, 8'h08, "R12 hour");
    rd(6'h07, 8'h03, "R12 day"); rd(6'h0B, 8'h00, "R12 cmd");
    // R8 matching time without tick
    @(posedge clk); #1 cur_min = 8'h30; cur_hour = 8'h08; cur_day = 8'h03;
    repeat (4) @(posedge clk);
    outs(1'b0, 1'b0, "R8 no tick");
    // R4 minute near miss, then hit
    tick(8'h31, 8'h08, 8'h03); outs(1'b0, 1'b0, "R4 minute miss");
    tick(8'h30, 8'h08, 8'h03); outs(1'b1, 1'b1, "R4 minute hit");
    // R9 hold and clear
    repeat (5) @(posedge clk);
    outs(1'b1, 1'b1, "R9 hold");
    rd(6'h0B, 8'h01, "R9 read flag");
    outs(1'b0, 1'b0, "R9 cleared");
    // R6 day miss
    tick(8'h30, 8'h08, 8'h04); outs(1'b0, 1'b0, "R6 day miss");
    // R5 mode bits
    tick(8'h30, 8'h48, 8'h03); outs(1'b0, 1'b0, "R5 12h vs 24h");
    wr(6'h05, 8'h68);
    tick(8'h30, 8'h48, 8'h03); outs(1'b0, 1'b0, "R5 AM vs PM");
    tick(8'h30, 8'h68, 8'h03); outs(1'b1, 1'b1, "R5 PM hit");
    rd(6'h0B, 8'h01, "R5 clear");
    // R11 mask gating
    tick(8'h30, 8'h68, 8'h03);
    wr(6'h0B, 8'h04); outs(1'b1, 1'b0, "R11 masked");
    wr(6'h0B, 8'h00); outs(1'b1, 1'b1, "R11 unmasked");
    rd(6'h0B, 8'h01, "R11 clear");
    // R7 masked fields
    wr(6'h03, 8'h80);
    tick(8'h45, 8'h68, 8'h03); outs(1'b1, 1'b1, "R7 minute dc");
    rd(6'h0B, 8'h01, "R7 clear1");
    wr(6'h05, 8'h80); wr(6'h07, 8'h80);
    tick(8'h12, 8'h23, 8'h06); outs(1'b1, 1'b1, "R7 all dc tick1");
    rd(6'h0B, 8'h01, "R7 clear2");
    tick(8'h59, 8'h51, 8'h01); outs(1'b1, 1'b1, "R7 all dc tick2");
    // R10 tick and read in same cycle
    rd(6'h0B, 8'h01, "R10 pre clear");
    @(posedge clk); #1 minute_tick = 1'b1; rd_en = 1'b1; addr = 6'h0B; chk_go = 1'b1;
    sb.push_back('{K_RD, 8'h00, "R10 old flag"});
    @(posedge clk); #1 minute_tick = 1'b0; rd_en = 1'b0; chk_go = 1'b0;
    outs(1'b1, 1'b1, "R10 flag kept");
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule